// File: doc/BRIEF.md
# Memory Contention Delay Generator

This block works out how many extra wait states a CPU memory access gets when it collides with the video controller's display fetches. The block keeps its own frame-relative T-state counter, which advances once per clock and returns to zero on the frame interrupt. From that counter it follows the raster position. While the raster is inside the displayed area, it applies a repeating eight-step delay pattern to accesses aimed at contended memory.

Which accesses count as contended depends on three things. The first is the 16 KiB window the address falls in. The second is the RAM bank paged into the top window. The third is a machine-variant select. On the latest variant, the access must also carry an active memory-request strobe. The result is a delay of 0 to 6 T-states. It is registered, so the value for an access shown during one clock appears after the next rising edge. The counter value is also brought out, so the surrounding controller can share the same raster time base.

Top module: `contention_delay_gen`

## Requirements
- R1: While `rst_n` is low, `delay` is 0 and `frame_pos` is 0.
- R2: `frame_pos` rises by one on every clock edge. It returns to 0 after 69887 when `variant` is 0, and after 70907 when `variant` is 1, 2 or 3.
- R3: When `frame_irq` is high at a clock edge, `frame_pos` is 0 after that edge.
- R4: Inside the active window, `delay` after an edge is 6,5,4,3,2,1,0,0 for column offsets 0 to 7 modulo 8 (counted from the window start). It is computed from the `frame_pos` value and the inputs that were present before that edge.
- R5: The window starts at `frame_pos` 14335 for `variant` 0, 14361 for `variant` 1, and 14365 for `variant` 2 or 3. Before that point, `delay` is 0.
- R6: Counted from the start point, a raster line is 224 T-states long for `variant` 0 and 228 for the other variants. Only the first 128 columns of each line, and only the first 192 lines, give a nonzero `delay`.
- R7: Addresses 0x4000 to 0x7FFF are always contended. Addresses 0x0000 to 0x3FFF and 0x8000 to 0xBFFF always give `delay` 0.
- R8: For addresses 0xC000 to 0xFFFF, contention depends on `variant`. With `variant` 0 they are never contended. With `variant` 1 they are contended for banks 1, 3, 5 and 7. With `variant` 2 or 3 they are contended for banks 4 to 7.
- R9: With `variant` 2 or 3, `delay` is 0 unless `mem_req` is high. With `variant` 0 or 1, `mem_req` has no effect.
- R10: `variant` 3 behaves exactly like `variant` 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_irq | input | 1 | Frame interrupt; zeroes the T-state counter |
| variant | input | 2 | Machine variant: 0 flat, 1 paged, 2 and 3 late |
| cpu_addr | input | 16 | CPU address of the current access |
| upper_bank | input | 3 | RAM bank paged at 0xC000 |
| mem_req | input | 1 | Memory-request strobe, active high |
| delay | output | 3 | Registered wait-state count, 0 to 6 |
| frame_pos | output | 17 | Current frame-relative T-state |

## Verification
Both outputs are due exactly one rising edge after the inputs they depend on. `delay` reflects the inputs and the counter value that were present before the edge. `frame_pos` shows the counter value after the edge, and is zero after an edge where `frame_irq` was high. The bench drives new inputs on the falling edge. It computes the expected pair from its own model of the counter and the raster. It compares at the following falling edge, so each check sits half a cycle after the edge that produced the result.

// File: rtl/contention_pkg.sv
package contention_pkg;

  typedef enum logic [1:0] {
    VAR_FLAT     = 2'd0,
    VAR_PAGED    = 2'd1,
    VAR_LATE     = 2'd2,
    VAR_LATE_ALT = 2'd3
  } variant_e;

  // Code 3 is an alias of the late variant.
  function automatic variant_e norm_variant(input logic [1:0] v);
    variant_e r;
    r = variant_e'(v);
    if (r == VAR_LATE_ALT) r = VAR_LATE;
    return r;
  endfunction

  typedef struct packed {
    logic       on;
    logic [2:0] phase;
  } win_s;

endpackage

// File: rtl/contention_frame_timer.sv
module contention_frame_timer #(
  parameter int LINE_FLAT    = 224,
  parameter int LINE_PAGED   = 228,
  parameter int LINES_FLAT   = 312,
  parameter int LINES_PAGED  = 311,
  parameter int START_FLAT   = 14335,
  parameter int START_PAGED  = 14361,
  parameter int START_LATE   = 14365,
  parameter int ACTIVE_COLS  = 128,
  parameter int ACTIVE_LINES = 192,
  parameter int PAT_LEN      = 8,
  parameter int T_W          = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_irq,
  input  contention_pkg::variant_e     var_sel,
  output logic [T_W-1:0]               frame_pos,
  output logic                         win_on,
  output logic [$clog2(PAT_LEN)-1:0]   win_phase
);
  localparam int FRAME_FLAT  = LINE_FLAT * LINES_FLAT;
  localparam int FRAME_PAGED = LINE_PAGED * LINES_PAGED;
  localparam int MAX_LINE    = (LINE_FLAT > LINE_PAGED) ? LINE_FLAT : LINE_PAGED;
  localparam int COL_W       = $clog2(MAX_LINE);
  localparam int LN_W        = $clog2(ACTIVE_LINES);
  localparam int PH_W        = $clog2(PAT_LEN);

  logic [T_W-1:0]   t_q, t_next;
  logic [T_W-1:0]   frame_last, start_pos;
  logic [COL_W-1:0] line_last;
  logic             rel_valid_q;
  logic [COL_W-1:0] rel_col_q;
  logic [LN_W-1:0]  rel_line_q;

  // Geometry chosen by the variant.
  always_comb begin
    unique case (var_sel)
      contention_pkg::VAR_FLAT: begin
        frame_last = T_W'(FRAME_FLAT - 1);
        line_last  = COL_W'(LINE_FLAT - 1);
        start_pos  = T_W'(START_FLAT);
      end
      contention_pkg::VAR_PAGED: begin
        frame_last = T_W'(FRAME_PAGED - 1);
        line_last  = COL_W'(LINE_PAGED - 1);
        start_pos  = T_W'(START_PAGED);
      end
      default: begin
        frame_last = T_W'(FRAME_PAGED - 1);
        line_last  = COL_W'(LINE_PAGED - 1);
        start_pos  = T_W'(START_LATE);
      end
    endcase
  end

  assign t_next = (t_q >= frame_last) ? '0 : t_q + T_W'(1);

  // Frame counter plus a tracker of the position relative to the
  // first contended T-state, which avoids any division.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q         <= '0;
      rel_valid_q <= 1'b0;
      rel_col_q   <= '0;
      rel_line_q  <= '0;
    end else if (frame_irq) begin
      t_q         <= '0;
      rel_valid_q <= 1'b0;
      rel_col_q   <= '0;
      rel_line_q  <= '0;
    end else begin
      t_q <= t_next;
      if (t_next == start_pos) begin
        rel_valid_q <= 1'b1;
        rel_col_q   <= '0;
        rel_line_q  <= '0;
      end else if (rel_valid_q) begin
        if (rel_col_q >= line_last) begin
          rel_col_q <= '0;
          if (rel_line_q == LN_W'(ACTIVE_LINES - 1)) begin
            rel_valid_q <= 1'b0;
            rel_line_q  <= '0;
          end else begin
            rel_line_q <= rel_line_q + LN_W'(1);
          end
        end else begin
          rel_col_q <= rel_col_q + COL_W'(1);
        end
      end
    end
  end

  assign frame_pos = t_q;
  assign win_on    = rel_valid_q && (rel_col_q < COL_W'(ACTIVE_COLS));
  assign win_phase = rel_col_q[PH_W-1:0];

endmodule

// File: rtl/contention_addr_qual.sv
module contention_addr_qual #(
  parameter int BANK_W = 3
) (
  input  logic [1:0]                 region,
  input  logic [BANK_W-1:0]          upper_bank,
  input  logic                       mem_req,
  input  contention_pkg::variant_e   var_sel,
  output logic                       contended
);
  localparam int NBANKS = 1 << BANK_W;

  logic [NBANKS-1:0] paged_mask, late_mask;
  logic              upper_hit;

  // Paged variant: odd banks. Late variant: upper half of the banks.
  genvar b;
  generate
    for (b = 0; b < NBANKS; b++) begin : g_mask
      assign paged_mask[b] = (b % 2) == 1;
      assign late_mask[b]  = b >= (NBANKS / 2);
    end
  endgenerate

  always_comb begin
    unique case (var_sel)
      contention_pkg::VAR_FLAT:  upper_hit = 1'b0;
      contention_pkg::VAR_PAGED: upper_hit = paged_mask[upper_bank];
      default:                   upper_hit = late_mask[upper_bank];
    endcase
  end

  always_comb begin
    unique case (region)
      2'b01:   contended = 1'b1;
      2'b11:   contended = upper_hit;
      default: contended = 1'b0;
    endcase
    if (var_sel == contention_pkg::VAR_LATE && !mem_req) contended = 1'b0;
  end

endmodule

// File: rtl/contention_pattern.sv
module contention_pattern #(
  parameter int PAT_LEN   = 8,
  parameter int MAX_DELAY = 6,
  parameter int D_W       = 3
) (
  input  logic [$clog2(PAT_LEN)-1:0] phase,
  output logic [D_W-1:0]             value
);
  logic [D_W-1:0] lut [PAT_LEN];

  // A descending ramp from MAX_DELAY, then zeros until the period ends.
  genvar i;
  generate
    for (i = 0; i < PAT_LEN; i++) begin : g_lut
      if (i < MAX_DELAY) begin : g_ramp
        assign lut[i] = D_W'(MAX_DELAY - i);
      end else begin : g_zero
        assign lut[i] = '0;
      end
    end
  endgenerate

  assign value = lut[phase];

endmodule

// File: rtl/contention_delay_gen.sv
module contention_delay_gen #(
  parameter int ADDR_W       = 16,
  parameter int BANK_W       = 3,
  parameter int LINE_FLAT    = 224,
  parameter int LINE_PAGED   = 228,
  parameter int LINES_FLAT   = 312,
  parameter int LINES_PAGED  = 311,
  parameter int START_FLAT   = 14335,
  parameter int START_PAGED  = 14361,
  parameter int START_LATE   = 14365,
  parameter int ACTIVE_COLS  = 128,
  parameter int ACTIVE_LINES = 192,
  parameter int PAT_LEN      = 8,
  parameter int MAX_DELAY    = 6,
  localparam int D_W = $clog2(MAX_DELAY + 1),
  localparam int T_W = $clog2(((LINE_FLAT * LINES_FLAT) > (LINE_PAGED * LINES_PAGED))
                              ? (LINE_FLAT * LINES_FLAT) : (LINE_PAGED * LINES_PAGED))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_irq,
  input  logic [1:0]        variant,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] upper_bank,
  input  logic              mem_req,
  output logic [D_W-1:0]    delay,
  output logic [T_W-1:0]    frame_pos
);
  localparam int PH_W = $clog2(PAT_LEN);

  contention_pkg::variant_e var_sel;
  logic                     win_on;
  logic [PH_W-1:0]          win_phase;
  logic                     contended;
  logic [D_W-1:0]           pat_val;
  logic [D_W-1:0]           delay_d, delay_q;
  logic                     unused_addr_bits;

  assign var_sel          = contention_pkg::norm_variant(variant);
  assign unused_addr_bits = ^cpu_addr[ADDR_W-3:0];

  contention_frame_timer #(
    .LINE_FLAT   (LINE_FLAT),
    .LINE_PAGED  (LINE_PAGED),
    .LINES_FLAT  (LINES_FLAT),
    .LINES_PAGED (LINES_PAGED),
    .START_FLAT  (START_FLAT),
    .START_PAGED (START_PAGED),
    .START_LATE  (START_LATE),
    .ACTIVE_COLS (ACTIVE_COLS),
    .ACTIVE_LINES(ACTIVE_LINES),
    .PAT_LEN     (PAT_LEN),
    .T_W         (T_W)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_irq(frame_irq),
    .var_sel  (var_sel),
    .frame_pos(frame_pos),
    .win_on   (win_on),
    .win_phase(win_phase)
  );

  contention_addr_qual #(
    .BANK_W(BANK_W)
  ) qual_i (
    .region    (cpu_addr[ADDR_W-1 -: 2]),
    .upper_bank(upper_bank),
    .mem_req   (mem_req),
    .var_sel   (var_sel),
    .contended (contended)
  );

  contention_pattern #(
    .PAT_LEN  (PAT_LEN),
    .MAX_DELAY(MAX_DELAY),
    .D_W      (D_W)
  ) pat_i (
    .phase(win_phase),
    .value(pat_val)
  );

  assign delay_d = (win_on && contended) ? pat_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delay_q <= '0;
    else        delay_q <= delay_d;
  end

  assign delay = delay_q;

endmodule

// File: rtl/contention_delay_gen_chk.sv
module contention_delay_gen_chk #(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 3,
  parameter int LINE_PAGED  = 228,
  parameter int START_PAGED = 14361,
  parameter int ACTIVE_COLS = 128,
  parameter int MAX_DELAY   = 6,
  parameter int FRAME_FLAT  = 69888,
  parameter int D_W         = 3,
  parameter int T_W         = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_irq,
  input logic [1:0]        variant,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [BANK_W-1:0] upper_bank,
  input logic              mem_req,
  input logic [D_W-1:0]    delay,
  input logic [T_W-1:0]    frame_pos
);
  logic unused_bank;
  assign unused_bank = ^upper_bank;

  always_comb begin
    if (!rst_n) assert_reset_clear_R1: assert (delay == '0 && frame_pos == '0);
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_irq |=> (frame_pos == $past(frame_pos) + T_W'(1)) || (frame_pos == '0));

  assert_flat_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_irq && variant == 2'd0 && frame_pos == T_W'(FRAME_FLAT - 1)) |=> frame_pos == '0);

  assert_irq_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> frame_pos == '0);

  assert_delay_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    delay <= D_W'(MAX_DELAY));

  assert_before_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 2'd1 && frame_pos < T_W'(START_PAGED)) |=> delay == '0);

  assert_outside_cols_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 2'd1 && frame_pos >= T_W'(START_PAGED)
     && ((int'(frame_pos) - START_PAGED) % LINE_PAGED) >= ACTIVE_COLS) |=> delay == '0);

  assert_free_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-2] |=> delay == '0);

  assert_flat_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 2'd0 && cpu_addr[ADDR_W-1 -: 2] == 2'b11) |=> delay == '0);

  assert_late_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (variant[1] && !mem_req) |=> delay == '0);

endmodule

bind contention_delay_gen contention_delay_gen_chk #(
  .ADDR_W     (ADDR_W),
  .BANK_W     (BANK_W),
  .LINE_PAGED (LINE_PAGED),
  .START_PAGED(START_PAGED),
  .ACTIVE_COLS(ACTIVE_COLS),
  .MAX_DELAY  (MAX_DELAY),
  .FRAME_FLAT (LINE_FLAT * LINES_FLAT),
  .D_W        (D_W),
  .T_W        (T_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_irq (frame_irq),
  .variant   (variant),
  .cpu_addr  (cpu_addr),
  .upper_bank(upper_bank),
  .mem_req   (mem_req),
  .delay     (delay),
  .frame_pos (frame_pos)
);

// File: tb/contention_delay_gen_tb.sv
module contention_delay_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_irq = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [2:0]  upper_bank = 3'd0;
  logic        mem_req = 1'b0;
  logic [2:0]  delay;
  logic [16:0] frame_pos;

  int checks = 0;
  int errors = 0;
  int m_t = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  contention_delay_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_irq (frame_irq),
    .variant   (variant),
    .cpu_addr  (cpu_addr),
    .upper_bank(upper_bank),
    .mem_req   (mem_req),
    .delay     (delay),
    .frame_pos (frame_pos)
  );

  function automatic int frame_len(input logic [1:0] v);
    return (v == 2'd0) ? 224 * 312 : 228 * 311;
  endfunction

  function automatic int exp_delay(input int t, input logic [1:0] v, input logic [15:0] a,
                                   input logic [2:0] bank, input bit req, output string why);
    int ll, st, rel, col, ln, ph;
    ll = (v == 2'd0) ? 224 : 228;
    st = (v == 2'd0) ? 14335 : (v == 2'd1) ? 14361 : 14365;
    if (t < st) begin why = "R5"; return 0; end
    rel = t - st;
    ln  = rel / ll;
    col = rel % ll;
    if (ln >= 192 || col >= 128) begin why = "R6"; return 0; end
    if (a[15:14] == 2'b00 || a[15:14] == 2'b10) begin why = "R7"; return 0; end
    if (a[15:14] == 2'b11) begin
      if (v == 2'd0 || (v == 2'd1 && !bank[0]) || (v[1] && !bank[2])) begin
        why = "R8"; return 0;
      end
    end
    if (v[1] && !req) begin why = "R9"; return 0; end
    why = (!v[1] && !req) ? "R9" : "R4";
    ph = col % 8;
    return (ph < 6) ? 6 - ph : 0;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d (model t=%0d)", tag, what, got, exp, m_t);
    end
  endtask

  // One cycle: drive at a falling edge, compare at the next falling edge.
  task automatic step(input bit irq, input logic [1:0] v, input logic [15:0] a,
                      input logic [2:0] bank, input bit req);
    int    e;
    string why, pre;
    pre = (v == 2'd3) ? "R10 " : "";
    e   = exp_delay(m_t, v, a, bank, req, why);
    frame_irq  = irq;
    variant    = v;
    cpu_addr   = a;
    upper_bank = bank;
    mem_req    = req;
    if (irq) m_t = 0;
    else     m_t = (m_t == frame_len(v) - 1) ? 0 : m_t + 1;
    @(negedge clk);
    check({pre, why}, "delay", int'(delay), e);
    check({pre, irq ? "R3" : "R2"}, "frame_pos", int'(frame_pos), m_t);
  endtask

  task automatic rand_step(input bit irq, input logic [1:0] v);
    logic [15:0] a;
    a = 16'($urandom);
    step(irq, v, a, 3'($urandom), 1'($urandom));
  endtask

  task automatic run(input logic [1:0] v, input int n);
    rand_step(1'b1, v);
    for (int k = 1; k < n; k++) rand_step(1'b0, v);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1", "delay in reset", int'(delay), 0);
    check("R1", "frame_pos in reset", int'(frame_pos), 0);
    rst_n = 1'b1;
    m_t = 0;

    // Directed: flat variant, full frame so the wrap is seen.
    run(2'd0, 69888 + 10);

    // Paged variant: sweep to just past the last active line.
    rand_step(1'b1, 2'd1);
    while (m_t < 14361 - 1) rand_step(1'b0, 2'd1);
    // Directed: eight steps of the pattern at the window start, contended window.
    for (int k = 0; k < 8; k++) step(1'b0, 2'd1, 16'h4000 + 16'(k), 3'd0, 1'b0);
    // Directed: odd and even upper bank at the same phase.
    step(1'b0, 2'd1, 16'hC123, 3'd3, 1'b1);
    step(1'b0, 2'd1, 16'hC123, 3'd2, 1'b1);
    while (m_t < 14361 + 192 * 228 + 300) rand_step(1'b0, 2'd1);

    // Late variant: strobe low then high at a contended address.
    rand_step(1'b1, 2'd2);
    while (m_t < 14365 - 1) rand_step(1'b0, 2'd2);
    step(1'b0, 2'd2, 16'h5000, 3'd0, 1'b0);
    step(1'b0, 2'd2, 16'h5000, 3'd0, 1'b1);
    step(1'b0, 2'd2, 16'hE000, 3'd4, 1'b1);
    step(1'b0, 2'd2, 16'hE000, 3'd3, 1'b1);
    for (int k = 0; k < 400; k++) rand_step(1'b0, 2'd2);
    // Interrupt inside the active window.
    rand_step(1'b1, 2'd2);
    for (int k = 0; k < 50; k++) rand_step(1'b0, 2'd2);

    // Alias code 3.
    run(2'd3, 14365 + 600);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at model t=%0d", m_t);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule